// File: doc/BRIEF.md
# BCD Real-Time Clock Register Block

This block is a calendar clock that keeps seconds, minutes, hours, day of month, month, two-digit year and weekday, each as a packed-BCD byte. A one-cycle pulse on `tick_i` marks one elapsed second. Software reaches the counters through a byte-wide register port with a combinational read path. The serial front end that would normally drive this port sits outside the block.

Software sets the time in three steps. It sets the halt bit in the control register, writes the time registers, and then clears the halt bit. To read the time consistently across several slow bus accesses, software first raises the snapshot bit. On that rising edge every live counter is copied into a shadow bank in one cycle. Software then sets the view bit so that reads of the time addresses return the shadow bank. The shadow bank stays fixed until the snapshot bit goes from 0 to 1 again.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00. The control register reads 0x00 and the status register reads 0x01.
- R2: While the halt bit (control bit 0) is clear, each `tick_i` pulse advances the seconds by one BCD step. While the halt bit is set, `tick_i` has no effect.
- R3: Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: The day wraps to 0x01 after the month's last day and carries into the month. Months 4, 6, 9 and 11 have 30 days, and the other months except February have 31. February has 29 days when the BCD year is a multiple of four and 28 days otherwise.
- R5: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00. The weekday (0 to 6) advances with every day carry and wraps from 6 to 0.
- R6: Writes to the time addresses (0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year, 0x06 weekday) take effect only while the halt bit is set. While the clock runs they are ignored.
- R7: A write to control (0x10) that moves bit 6 from 0 to 1 copies all live counters into the shadow bank. Writes that leave bit 6 at 1 do not refresh the bank. While bit 7 is set, time reads return the shadow bank; otherwise they return the live counters.
- R8: Reads keep only the valid bits and return the unused upper bits as zero. The valid widths are 7 bits for seconds and minutes, 6 for hours and day, 5 for month, 8 for year and 3 for weekday. Written values are stored with the same masks. Control reads back bits 7, 6 and 0, and unmapped addresses read 0x00.
- R9: The status register (0x11) reports, in bit 0, that the clock is running (halt clear). In bit 1 it reports that a snapshot has been taken since reset. The other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
The bench builds the block with its default `ADDR_W` of 5. This width covers the time addresses, control at 0x10, status at 0x11 and unmapped holes such as 0x08. The second tick is a plain input, so the bench preloads times just before each boundary and reaches every carry with a single pulse. The preloaded times cover minute, hour, month-end, February in leap and common years, and year rollover. A table of such preloaded times and their expected successors drives most checks. Directed steps then cover ignored writes and ticks, masked writes, and holding and refreshing the shadow bank.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int NF = 7;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h11);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NF - 1);

  logic [7:0] live [NF];
  logic [7:0] shad [NF];
  logic       halt_q, snap_q, view_q, took_q;

  function automatic logic [7:0] fmask(input int i);
    case (i)
      0, 1:    fmask = 8'h7F;
      2, 3:    fmask = 8'h3F;
      4:       fmask = 8'h1F;
      5:       fmask = 8'hFF;
      default: fmask = 8'h07;
    endcase
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] v);
    binc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02:                      month_end = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

  wire c_sec = live[0] == 8'h59;
  wire c_min = c_sec && live[1] == 8'h59;
  wire c_hr  = c_min && live[2] == 8'h23;
  wire c_day = c_hr && live[3] == month_end(live[4], live[5]);
  wire c_mon = c_day && live[4] == 8'h12;
  wire run   = !halt_q && tick_i;
  wire wr_ctl = wr_en_i && addr_i == A_CTRL;
  wire snap_edge = wr_ctl && wdata_i[6] && !snap_q;

  logic [7:0] nxt [NF];
  always_comb begin
    nxt[0] = c_sec ? 8'h00 : binc(live[0]);
    nxt[1] = !c_sec ? live[1] : (c_min ? 8'h00 : binc(live[1]));
    nxt[2] = !c_min ? live[2] : (c_hr ? 8'h00 : binc(live[2]));
    nxt[3] = !c_hr ? live[3] : (c_day ? 8'h01 : binc(live[3]));
    nxt[4] = !c_day ? live[4] : (c_mon ? 8'h01 : binc(live[4]));
    nxt[5] = !c_mon ? live[5] : (live[5] == 8'h99 ? 8'h00 : binc(live[5]));
    nxt[6] = !c_hr ? live[6] : (live[6] == 8'h06 ? 8'h00 : live[6] + 8'h01);
  end

  generate
    for (genvar i = 0; i < NF; i++) begin : g_field
      localparam logic [7:0] RV = (i == 3 || i == 4) ? 8'h01 : 8'h00;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          live[i] <= RV;
          shad[i] <= RV;
        end else begin
          if (run)
            live[i] <= nxt[i];
          else if (halt_q && wr_en_i && addr_i == ADDR_W'(i))
            live[i] <= wdata_i & fmask(i);
          if (snap_edge)
            shad[i] <= live[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      snap_q <= 1'b0;
      view_q <= 1'b0;
      took_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        halt_q <= wdata_i[0];
        snap_q <= wdata_i[6];
        view_q <= wdata_i[7];
      end
      if (snap_edge)
        took_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i <= A_LAST)
      rdata_o = view_q ? shad[addr_i[2:0]] : live[addr_i[2:0]];
    else if (addr_i == A_CTRL)
      rdata_o = {view_q, snap_q, 5'b0, halt_q};
    else if (addr_i == A_STAT)
      rdata_o = {6'b0, took_q, !halt_q};
  end
endmodule

// File: rtl/bcd_rtc_sva.sv
module bcd_rtc_sva #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              halt_q,
  input logic              snap_q,
  input logic [7:0]        sec_q,
  input logic [7:0]        day_q,
  input logic [7:0]        shd_sec
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h11);

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en_i) |=> ($stable(sec_q) && $stable(day_q)));

  assert_tick_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && tick_i && !wr_en_i) |=> (sec_q != $past(sec_q)));

  assert_run_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !tick_i && wr_en_i && addr_i == '0) |=> $stable(sec_q));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == A_CTRL && wdata_i[6]) |=> $stable(shd_sec));

  assert_snapshot_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_CTRL && wdata_i[6] && !snap_q) |=> (shd_sec == $past(sec_q)));

  assert_status_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_STAT) |-> (rdata_o[0] == !halt_q && rdata_o[7:2] == 6'b0));
endmodule

bind bcd_rtc bcd_rtc_sva #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .halt_q(halt_q), .snap_q(snap_q), .sec_q(live[0]), .day_q(live[3]),
  .shd_sec(shad[0])
);

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;
  localparam int ADDR_W = 5;
  localparam int NV = 14;
  localparam logic [4:0] CTRL = 5'h10, STAT = 5'h11;

  // {sec,min,hour,day,month,year,wday} preset, then expected after one tick
  localparam logic [111:0] VEC [NV] = '{
    {56'h00_00_00_01_01_00_00, 56'h01_00_00_01_01_00_00},
    {56'h59_00_00_01_01_00_00, 56'h00_01_00_01_01_00_00},
    {56'h09_19_09_09_09_09_00, 56'h10_19_09_09_09_09_00},
    {56'h59_59_09_30_11_12_02, 56'h00_00_10_30_11_12_02},
    {56'h59_59_23_15_06_24_03, 56'h00_00_00_16_06_24_04},
    {56'h59_59_23_31_01_23_06, 56'h00_00_00_01_02_23_00},
    {56'h59_59_23_28_02_23_02, 56'h00_00_00_01_03_23_03},
    {56'h59_59_23_28_02_24_02, 56'h00_00_00_29_02_24_03},
    {56'h59_59_23_29_02_24_03, 56'h00_00_00_01_03_24_04},
    {56'h59_59_23_28_02_30_01, 56'h00_00_00_01_03_30_02},
    {56'h59_59_23_28_02_16_01, 56'h00_00_00_29_02_16_02},
    {56'h59_59_23_30_04_25_01, 56'h00_00_00_01_05_25_02},
    {56'h59_59_23_30_07_25_01, 56'h00_00_00_31_07_25_02},
    {56'h59_59_23_31_12_99_05, 56'h00_00_00_01_01_00_06}
  };

  logic clk = 0, rst_n = 0, tick_i = 0, wr_en_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  bcd_rtc #(.ADDR_W(ADDR_W)) dut_i (.*);

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_en_i = 1;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1;
    @(negedge clk); tick_i = 0;
  endtask

  task automatic chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); addr_i = a; #1;
    n_chk++;
    if (rdata_o !== exp) begin
      n_err++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, a, rdata_o, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 sec", 0, 8'h00); chk("R1 min", 1, 8'h00); chk("R1 hour", 2, 8'h00);
    chk("R1 day", 3, 8'h01); chk("R1 month", 4, 8'h01); chk("R1 year", 5, 8'h00);
    chk("R1 wday", 6, 8'h00); chk("R1 ctrl", CTRL, 8'h00); chk("R1 stat", STAT, 8'h01);

    // R3 R4 R5 table of carries
    for (int i = 0; i < NV; i++) begin
      wr(CTRL, 8'h01);
      for (int f = 0; f < 7; f++) wr(5'(f), VEC[i][111-8*f -: 8]);
      wr(CTRL, 8'h00);
      tick();
      for (int f = 0; f < 7; f++) chk("R3 R4 R5 table", 5'(f), VEC[i][55-8*f -: 8]);
    end

    // R2 tick ignored while halted, counts when running
    wr(CTRL, 8'h01); wr(0, 8'h20); tick(); tick();
    chk("R2 halted tick", 0, 8'h20);
    wr(CTRL, 8'h00); tick(); tick();
    chk("R2 running ticks", 0, 8'h22);

    // R6 write ignored while running
    wr(0, 8'h45);
    chk("R6 run write", 0, 8'h22);
    wr(4, 8'h07);
    chk("R6 run write month", 4, 8'h01);

    // R8 masks and unmapped address
    wr(CTRL, 8'h01);
    wr(2, 8'hD5); chk("R8 hour mask", 2, 8'h15);
    wr(4, 8'hE9); chk("R8 month mask", 4, 8'h09);
    wr(6, 8'h0E); chk("R8 wday mask", 6, 8'h06);
    wr(5, 8'h87); chk("R8 year full", 5, 8'h87);
    chk("R8 unmapped", 5'h08, 8'h00);
    wr(CTRL, 8'h3F); chk("R8 ctrl bits", CTRL, 8'h01);
    chk("R9 stat halted", STAT, 8'h00);

    // R7 snapshot
    wr(0, 8'h10);
    wr(CTRL, 8'h41);
    chk("R9 stat snapshot", STAT, 8'h02);
    wr(CTRL, 8'h00); tick(); tick(); tick();
    chk("R7 live view", 0, 8'h13);
    wr(CTRL, 8'h80);
    chk("R7 shadow view", 0, 8'h10);
    chk("R7 shadow hour", 2, 8'h15);
    wr(CTRL, 8'hC0);
    chk("R7 refreshed", 0, 8'h13);
    tick(); wr(CTRL, 8'hC0);
    chk("R7 no re-edge", 0, 8'h13);
    wr(CTRL, 8'h40);
    chk("R7 live again", 0, 8'h14);
    chk("R8 ctrl readback", CTRL, 8'h40);
    chk("R9 stat running", STAT, 8'h03);
    summary();
  end
endmodule